// File: doc/BRIEF.md
# Exception Recognition Controller

This block decides which exception a small processor core takes and at which moment. It watches two checking points that the core announces with strobes. The first comes just before an instruction starts. Here it looks for pending interrupts and then for a deferred trace trap. The second comes while an instruction executes. There it considers one of seven mutually exclusive execution traps, plus an interrupt if the instruction may be interrupted. When an exception is chosen, it comes out on a one-hot select bus together with its vector number and a return-address select.

Interrupts first run an interrupt-acknowledge bus cycle. The block raises `ack_req` with a fixed address and waits for `ack_done`. A maskable interrupt takes its vector from `ack_data`. The non-maskable interrupt always uses vector 1.

The decision leaves the block on a valid/ready interface. `exc_valid` stays high, with `exc_sel`, `exc_vector`, `ret_next` and `int_disable` held constant, until the core raises `exc_ready`. A decision is consumed on a clock edge where valid and ready are both high. The check strobes are only sampled while the block is idle. The acknowledge handshake and the decision handshake act as the back-pressure on new checks.

Top module: `exc_sel_ctrl`

## Requirements
- R1: The non-maskable request is detected only on a high-to-low transition of `nmi_n`, after a two-flop synchronizer. It stays pending until its acknowledge cycle completes. Holding `nmi_n` low does not raise it again.
- R2: A taken non-maskable interrupt raises `ack_req` with `ack_addr` = 0xFFFF00. Its vector is 1, whatever value `ack_data` carries at `ack_done`.
- R3: At a pre-instruction check (`chk_boundary`), a pending non-maskable interrupt beats a maskable one. A maskable interrupt needs both `irq_req` and `irq_en`. It acknowledges at 0xFFFE00 and takes `ack_data` as its vector.
- R4: At a pre-instruction check with no interrupt, `trace_pend` = 1 produces the trace trap (vector 9). If `trace_pend` is also 0, nothing happens and the instruction may start.
- R5: At an execution check (`chk_exec`), a set `trap_req` bit selects its trap. Bit 0 is coprocessor (vector 3), bit 1 privilege (4), bit 2 supervisor call (5), bit 3 divide by zero (6), bit 4 flag (7), bit 5 breakpoint (8) and bit 6 undefined opcode (10). If several bits are set, the lowest bit wins.
- R6: At an execution check, an interrupt is taken only when `interruptible` = 1 and no trap bit is set. A trap is always signalled first, and the interrupt stays pending for the next check.
- R7: `ret_next` is 1 only for the trace trap (resume at the next instruction). It is 0 for every other exception, which resume at the first byte of the current instruction.
- R8: `int_disable` is 1 with interrupt decisions and 0 with every trap decision, so traps leave maskable interrupts enabled.
- R9: An execution check with no trap and no admissible interrupt produces neither `ack_req` nor `exc_valid`, so the instruction completes.
- R10: `exc_sel` is one-hot while `exc_valid` is high. Bit order is 0 non-maskable, 1 maskable, 2 trace, 3 coprocessor, 4 privilege, 5 supervisor call, 6 divide by zero, 7 flag, 8 breakpoint, 9 undefined opcode. All outputs hold stable until `exc_ready`, and after reset the block is idle with no request.
- R11: Check strobes that arrive while an acknowledge cycle or an unaccepted decision is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_n | input | 1 | Asynchronous non-maskable interrupt pin, active low |
| irq_req | input | 1 | Maskable interrupt request level |
| irq_en | input | 1 | Maskable interrupt enable |
| trace_pend | input | 1 | Deferred trace trap pending flag |
| chk_boundary | input | 1 | Pre-instruction check strobe |
| chk_exec | input | 1 | In-instruction check strobe |
| interruptible | input | 1 | Current instruction may be interrupted |
| trap_req | input | 7 | Execution trap requests, bit map in R5 |
| ack_req | output | 1 | Interrupt-acknowledge bus cycle request |
| ack_addr | output | 24 | Acknowledge cycle address |
| ack_done | input | 1 | Acknowledge cycle completed |
| ack_data | input | 8 | Data returned by the acknowledge cycle |
| exc_valid | output | 1 | Decision valid |
| exc_ready | input | 1 | Core accepts the decision |
| exc_sel | output | 10 | One-hot selected exception, bit map in R10 |
| exc_vector | output | 8 | Vector number |
| ret_next | output | 1 | 1: save next instruction address; 0: current instruction |
| int_disable | output | 1 | Decision is an interrupt; maskable interrupts to be masked |

## Verification
Random patterns mix every combination of `irq_req`, `irq_en`, `trace_pend`, `interruptible` and multi-bit trap words with occasional non-maskable edges. Boundary checks alone separate the interrupt-over-trace order, and execution checks with several trap bits set show the lowest-bit priority. Directed cases cover a long low level on `nmi_n`, which must not re-trigger. They also cover a trap and interrupt in the same instruction, which must yield the trap first and the interrupt at the next boundary, and random `ack_data` against the forced non-maskable vector. Strobes pulsed during an open acknowledge cycle, along with random ready stalls, separate correct ignoring and holding from leaked or overwritten decisions.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NTRAP = 7;
  localparam int NKIND = 10;
  localparam int VEC_W = 8;

  typedef enum logic [3:0] {
    K_NMI   = 4'd0,
    K_INT   = 4'd1,
    K_TRC   = 4'd2,
    K_SLAVE = 4'd3,
    K_ILL   = 4'd4,
    K_SVC   = 4'd5,
    K_DVZ   = 4'd6,
    K_FLG   = 4'd7,
    K_BPT   = 4'd8,
    K_UND   = 4'd9
  } exc_kind_e;

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_OFFER} ctl_state_e;

  // Fixed vector numbers; the maskable interrupt vector comes from the bus.
  function automatic logic [VEC_W-1:0] fixed_vector(exc_kind_e k);
    case (k)
      K_NMI:   fixed_vector = VEC_W'(1);
      K_TRC:   fixed_vector = VEC_W'(9);
      K_UND:   fixed_vector = VEC_W'(10);
      K_INT:   fixed_vector = '0;
      default: fixed_vector = VEC_W'(k);
    endcase
  endfunction
endpackage

// File: rtl/exc_nmi_edge.sv
module exc_nmi_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  logic [SYNC:0] sh;
  logic          fall;

  assign fall = sh[SYNC] & ~sh[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      pend <= 1'b0;
    end else begin
      sh   <= {sh[SYNC-1:0], pin_n};
      pend <= fall | (pend & ~clr);
    end
  end
endmodule

// File: rtl/exc_trap_pick.sv
module exc_trap_pick #(
  parameter int N  = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/exc_sel_ctrl.sv
module exc_sel_ctrl
  import exc_pkg::*;
#(
  parameter int              ADDR_W       = 24,
  parameter int              SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] NMI_ACK_ADDR = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] INT_ACK_ADDR = 24'hFFFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic              trace_pend,
  input  logic              chk_boundary,
  input  logic              chk_exec,
  input  logic              interruptible,
  input  logic [NTRAP-1:0]  trap_req,
  output logic              ack_req,
  output logic [ADDR_W-1:0] ack_addr,
  input  logic              ack_done,
  input  logic [VEC_W-1:0]  ack_data,
  output logic              exc_valid,
  input  logic              exc_ready,
  output logic [NKIND-1:0]  exc_sel,
  output logic [VEC_W-1:0]  exc_vector,
  output logic              ret_next,
  output logic              int_disable
);
  localparam int TIW = $clog2(NTRAP);

  ctl_state_e       st;
  exc_kind_e        kind_q, nk;
  logic [VEC_W-1:0] vec_q;
  logic             ret_q;
  logic             nmi_pend, nmi_clr;
  logic             trap_any;
  logic [TIW-1:0]   trap_idx;
  logic             irq_live, take, to_ack;

  exc_nmi_edge #(.SYNC(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_n(nmi_n), .clr(nmi_clr), .pend(nmi_pend)
  );

  exc_trap_pick #(.N(NTRAP)) u_pick (
    .req(trap_req), .any(trap_any), .idx(trap_idx)
  );

  assign irq_live = irq_req & irq_en;
  assign nmi_clr  = (st == S_ACK) & ack_done & (kind_q == K_NMI);

  // Decision at the two checking points; strobes count only when idle.
  always_comb begin
    take   = 1'b0;
    to_ack = 1'b0;
    nk     = K_NMI;
    if (st == S_IDLE) begin
      if (chk_boundary) begin
        if (nmi_pend) begin
          take = 1'b1; to_ack = 1'b1; nk = K_NMI;
        end else if (irq_live) begin
          take = 1'b1; to_ack = 1'b1; nk = K_INT;
        end else if (trace_pend) begin
          take = 1'b1; nk = K_TRC;
        end
      end else if (chk_exec) begin
        if (trap_any) begin
          take = 1'b1;
          nk   = exc_kind_e'(4'(K_SLAVE) + 4'(trap_idx));
        end else if (interruptible && nmi_pend) begin
          take = 1'b1; to_ack = 1'b1; nk = K_NMI;
        end else if (interruptible && irq_live) begin
          take = 1'b1; to_ack = 1'b1; nk = K_INT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= K_NMI;
      vec_q  <= '0;
      ret_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          kind_q <= nk;
          vec_q  <= fixed_vector(nk);
          ret_q  <= (nk == K_TRC);
          st     <= to_ack ? S_ACK : S_OFFER;
        end
        S_ACK: if (ack_done) begin
          vec_q <= (kind_q == K_NMI) ? VEC_W'(1) : ack_data;
          st    <= S_OFFER;
        end
        S_OFFER: if (exc_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack_req     = (st == S_ACK);
  assign ack_addr    = (kind_q == K_NMI) ? NMI_ACK_ADDR : INT_ACK_ADDR;
  assign exc_valid   = (st == S_OFFER);
  assign exc_sel     = exc_valid ? (NKIND'(1) << kind_q) : '0;
  assign exc_vector  = vec_q;
  assign ret_next    = ret_q;
  assign int_disable = exc_valid & ((kind_q == K_NMI) | (kind_q == K_INT));
endmodule

// File: rtl/exc_sel_ctrl_chk.sv
module exc_sel_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_req,
  input logic              ack_done,
  input logic [ADDR_W-1:0] ack_addr,
  input logic              exc_valid,
  input logic              exc_ready,
  input logic [9:0]        exc_sel,
  input logic [7:0]        exc_vector,
  input logic              ret_next,
  input logic              int_disable
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $countones(exc_sel) == 1);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> exc_sel == '0 && !int_disable);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_ready |=> exc_valid && $stable(exc_sel) && $stable(exc_vector)
      && $stable(ret_next));

  a_r11_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !ack_done |=> ack_req && $stable(ack_addr));

  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req && exc_valid));

  a_r2_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_sel[0] |-> exc_vector == 8'd1);

  a_r7_ret_sel: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ret_next == exc_sel[2]);

  a_r8_trap_keeps_int: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_sel[9:2] != '0) |-> !int_disable);
endmodule

bind exc_sel_ctrl exc_sel_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/exc_sel_ctrl_test.sv
`timescale 1ns/1ps
module exc_sel_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_n = 1'b1, irq_req = 1'b0, irq_en = 1'b0, trace_pend = 1'b0;
  logic       chk_boundary = 1'b0, chk_exec = 1'b0, interruptible = 1'b0;
  logic [6:0] trap_req = '0;
  logic       ack_req, ack_done = 1'b0;
  logic [23:0] ack_addr;
  logic [7:0] ack_data = '0;
  logic       exc_valid, exc_ready = 1'b0;
  logic [9:0] exc_sel;
  logic [7:0] exc_vector;
  logic       ret_next, int_disable;

  int  checks = 0;
  int  errors = 0;
  bit  model_nmi = 1'b0;
  bit  done = 1'b0;
  int  unused_seed;

  always #4 clk = ~clk;

  exc_sel_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int exp_vec(int k, logic [7:0] d);
    case (k)
      0: return 1;
      1: return int'(d);
      2: return 9;
      9: return 10;
      default: return k;
    endcase
  endfunction

  function automatic int exp_bound(bit nmi, bit irq, bit en, bit tr);
    if (nmi) return 0;
    if (irq && en) return 1;
    if (tr) return 2;
    return -1;
  endfunction

  function automatic int exp_exec(logic [6:0] t, bit nmi, bit irq, bit en, bit ok);
    for (int i = 0; i < 7; i++) if (t[i]) return 3 + i;
    if (ok && nmi) return 0;
    if (ok && irq && en) return 1;
    return -1;
  endfunction

  function automatic string req_of(int k, bit bnd);
    if (k < 0) return bnd ? "R4" : "R9";
    if (k == 0) return "R2";
    if (k == 1) return bnd ? "R3" : "R6";
    if (k == 2) return "R4";
    return "R5";
  endfunction

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    repeat (4) @(negedge clk);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    model_nmi = 1'b1;
  endtask

  // Issue one check strobe and follow the decision through both handshakes.
  task automatic run_check(input bit bnd, input int k, input logic [7:0] d, input int hold);
    string r;
    logic [9:0] sel0;
    r = req_of(k, bnd);
    if (bnd) chk_boundary = 1'b1; else chk_exec = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_boundary = 1'b0; chk_exec = 1'b0;
    if (k < 0) begin
      chk(!ack_req && !exc_valid, r, {ack_req, exc_valid}, 0);
      return;
    end
    if (k <= 1) begin
      chk(ack_req && !exc_valid, r, {ack_req, exc_valid}, 2);
      chk(ack_addr == ((k == 0) ? 24'hFFFF00 : 24'hFFFE00), r, ack_addr,
          (k == 0) ? 24'hFFFF00 : 24'hFFFE00);
      ack_done = 1'b1; ack_data = d;
      @(posedge clk); @(negedge clk);
      ack_done = 1'b0;
    end
    chk(exc_valid, r, exc_valid, 1);
    chk(exc_sel == 10'(1) << k, r, exc_sel, 1 << k);
    chk(int'(exc_vector) == exp_vec(k, d), r, exc_vector, exp_vec(k, d));
    chk(ret_next == (k == 2), "R7", ret_next, k == 2);
    chk(int_disable == (k <= 1), "R8", int_disable, k <= 1);
    sel0 = exc_sel;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk(exc_valid && exc_sel == sel0, "R10", exc_sel, sel0);
    end
    exc_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    exc_ready = 1'b0;
    chk(!exc_valid && !ack_req, "R10", exc_valid, 0);
    if (k == 0) model_nmi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_req && !exc_valid && exc_sel == '0, "R10", {ack_req, exc_valid}, 0);

    // R4: nothing pending at boundary
    run_check(1, -1, 8'h00, 0);

    // R1: level held low takes only one NMI
    nmi_n = 1'b0;
    repeat (4) @(negedge clk);
    run_check(1, 0, 8'hA7, 1);
    repeat (3) @(negedge clk);
    run_check(1, -1, 8'h00, 0);
    chk(!ack_req, "R1", ack_req, 0);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3: NMI beats maskable and trace, vector forced despite bus data
    nmi_pulse();
    irq_req = 1; irq_en = 1; trace_pend = 1;
    run_check(1, 0, 8'h55, 2);
    // R3: then maskable with bus vector
    run_check(1, 1, 8'h3C, 0);
    // R4: maskable disabled, trace wins
    irq_en = 0;
    run_check(1, 2, 8'h00, 1);

    // R5/R6: trap with live interrupt -> trap first, interrupt at next boundary
    irq_en = 1; trace_pend = 0; interruptible = 1; trap_req = 7'h50;
    run_check(0, 7, 8'h00, 0);
    trap_req = '0;
    run_check(1, 1, 8'h91, 0);
    // R6: not interruptible -> nothing; interruptible -> interrupt
    interruptible = 0;
    run_check(0, -1, 8'h00, 0);
    interruptible = 1;
    run_check(0, 1, 8'h22, 0);
    // R5: undefined opcode alone
    irq_req = 0; trap_req = 7'h40;
    run_check(0, 9, 8'h00, 0);
    trap_req = '0;

    // R11: strobes during an open acknowledge cycle are ignored
    irq_req = 1; irq_en = 1;
    chk_boundary = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_boundary = 1'b0;
    trap_req = 7'h01; trace_pend = 1; chk_exec = 1'b1; chk_boundary = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_exec = 1'b0; trap_req = '0; trace_pend = 0;
    chk(ack_req && ack_addr == 24'hFFFE00, "R11", ack_addr, 24'hFFFE00);
    ack_done = 1'b1; ack_data = 8'h77;
    @(posedge clk); @(negedge clk);
    ack_done = 1'b0;
    chk(exc_sel == 10'h002 && exc_vector == 8'h77, "R11", exc_sel, 10'h002);
    exc_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    exc_ready = 1'b0;
    @(negedge clk);
    chk(!exc_valid && !ack_req, "R11", {exc_valid, ack_req}, 0);
    irq_req = 0;

    // Random mix
    for (int it = 0; it < 400; it++) begin
      bit bnd;
      int k;
      if ($urandom_range(0, 7) == 0) nmi_pulse();
      irq_req = 1'($urandom); irq_en = 1'($urandom);
      trace_pend = 1'($urandom); interruptible = 1'($urandom);
      trap_req = ($urandom_range(0, 1) == 0) ? 7'h00 : 7'($urandom);
      bnd = 1'($urandom);
      k = bnd ? exp_bound(model_nmi, irq_req, irq_en, trace_pend)
              : exp_exec(trap_req, model_nmi, irq_req, irq_en, interruptible);
      run_check(bnd, k, 8'($urandom), $urandom_range(0, 2));
      @(negedge clk);
    end

    finish_up();
  end
endmodule